// File: doc/BRIEF.md
# Converter Result Byte-Handshake Sequencer

This block sits between a converter's control logic and a byte-wide bus. It keeps the last conversion result, a 16-bit magnitude with a polarity flag and an over-range flag, and hands it out as three bytes. In direct mode a host reads the result on its own terms: it drives the chip-enable/load line and one of the three byte-enable lines, and the block puts the selected byte on the three-state data bus.

A rising edge on the mode input switches the block into handshake mode. The block then drives the byte-enable and chip-enable/load lines itself and presents the high, middle and low bytes in that order. A send-enable input from the receiver paces the transfer. The block holds the current byte while send-enable is high and moves to the next byte on each clock edge where it is low. The result-capture pulse is held off for the whole transfer, so the bytes cannot change partway through. After the low byte is taken the block releases the lines and returns to direct mode. A status output follows the conversion cycle and is not affected by the mode.

Top module: `byte_handshake_seq`

## Requirements
- R1: When the mode input goes from 0 to 1 and send-enable is 0, the block enters handshake mode on that clock edge, and the high byte is presented from the next cycle on. Holding the mode input at 1 afterwards never starts a second transfer.
- R2: In direct mode the block drives none of the byte-enable or chip-enable/load lines. When the host drives chip-enable/load to 1, the block drives the byte whose enable the host raises, with priority high over middle over low. With chip-enable/load at 0, or with no enable raised, the data bus is left at high impedance.
- R3: In handshake mode the block drives chip-enable/load to 1, drives all three byte enables, and never has more than one of them at 1.
- R4: The bytes go out in the order high, middle, low. The block moves to the next byte on a clock edge where send-enable is 0 and holds the current byte (same enable, same data) while send-enable is 1.
- R5: Byte layout of the 24 transferred bits {polarity, over-range, result[15:0], six zeros}: high = {polarity, over-range, result[15:10]}, middle = result[9:2], low = {result[1:0], 6'b000000}.
- R6: In direct mode the latch-pulse output equals the conversion-complete strobe, and the result on the inputs is captured on that clock edge. In handshake mode the latch pulse stays 0 and the stored result does not change.
- R7: On the clock edge where the low byte is taken (send-enable 0), the block returns to direct mode and releases the enable and chip-enable/load lines.
- R8: A rising edge on the mode input while send-enable is 1 leaves the block in direct mode, so a system with send-enable tied high never enters handshake mode.
- R9: Status goes to 1 on the clock edge after a zero-crossing event and back to 0 on the clock edge after a conversion-complete strobe, with zero-crossing taking priority. This holds the same way in both modes.
- R10: After reset the block is in direct mode, status is 0 and the stored result is all zeros.

Top module port order is listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low power-on reset |
| mode_i | input | 1 | Mode input; a rising edge requests a handshake transfer |
| send_en_i | input | 1 | Receiver pacing; 0 = ready to take a byte, 1 = hold |
| conv_done_i | input | 1 | Conversion-complete strobe |
| result_i | input | DATA_W (16) | Conversion magnitude |
| polarity_i | input | 1 | Sign of the conversion |
| overrange_i | input | 1 | Over-range flag |
| zero_cross_i | input | 1 | Zero-crossing event from the converter control |
| data_io | inout | BYTE_W (8) | Three-state byte data bus |
| hi_en_io | inout | 1 | High-byte enable (host-driven in direct mode, block-driven in handshake) |
| mid_en_io | inout | 1 | Middle-byte enable |
| lo_en_io | inout | 1 | Low-byte enable |
| ce_load_io | inout | 1 | Chip-enable input in direct mode, load output in handshake |
| latch_pulse_o | output | 1 | Result-capture pulse |
| status_o | output | 1 | Conversion status |

## Verification
In direct mode the data bus follows the host's enables in the same cycle, so the bench changes the enables at a falling edge and samples the bus shortly after. Entry into handshake mode, each byte step, the exit, result capture and status each take effect one clock edge after the inputs that cause them. For these the bench sets its inputs at a falling edge, updates its own byte index and status model on the rising edge in between, and compares at the next falling edge. The latch pulse is combinational and is checked right after the strobe is raised.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
   typedef enum logic [1:0] {
      PH_DIRECT = 2'd0,
      PH_HIGH   = 2'd1,
      PH_MID    = 2'd2,
      PH_LOW    = 2'd3
   } phase_t;

   localparam int unsigned HSQ_NBYTES = 3;
endpackage

// File: rtl/hsq_mode_detect.sv
module hsq_mode_detect #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mode_i,
   input  logic send_en_i,
   input  logic busy_i,
   output logic start_o
);
   logic mode_s;
   logic mode_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign mode_s = mode_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else if (SYNC_STAGES == 1) sync_q <= mode_i;
            else sync_q <= {sync_q[SYNC_STAGES-2:0], mode_i};
         end
         assign mode_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= 1'b0;
      else         mode_q <= mode_s;
   end

   // rising edge only; a held-high send-enable suppresses the set
   assign start_o = mode_s & ~mode_q & ~send_en_i & ~busy_i;
endmodule

// File: rtl/hsq_result_latch.sv
module hsq_result_latch #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 3
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          conv_done_i,
   input  logic                          inhibit_i,
   input  logic [DATA_W-1:0]             result_i,
   input  logic                          polarity_i,
   input  logic                          overrange_i,
   output logic                          latch_pulse_o,
   output logic [NBYTES-1:0][BYTE_W-1:0] bytes_o
);
   localparam int unsigned WORD_W = NBYTES * BYTE_W;
   localparam int          PAD_W  = int'(WORD_W) - int'(DATA_W) - 2;

   logic [WORD_W-1:0] word_d;
   logic [WORD_W-1:0] word_q;

   generate
      if (PAD_W < 0) begin : g_bad
         $error("hsq_result_latch: result and flags do not fit the byte frame");
      end
      if (PAD_W > 0) begin : g_pad
         assign word_d = {polarity_i, overrange_i, result_i, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign word_d = {polarity_i, overrange_i, result_i};
      end
   endgenerate

   assign latch_pulse_o = conv_done_i & ~inhibit_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            word_q <= '0;
      else if (latch_pulse_o) word_q <= word_d;
   end

   generate
      for (genvar k = 0; k < NBYTES; k++) begin : g_slice
         assign bytes_o[k] = word_q[(k+1)*BYTE_W-1 -: BYTE_W];
      end
   endgenerate
endmodule

// File: rtl/hsq_sequencer.sv
module hsq_sequencer
   import hsq_pkg::*;
(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  start_i,
   input  logic                  send_en_i,
   output logic                  active_o,
   output logic [HSQ_NBYTES-1:0] sel_o
);
   phase_t phase_q;
   phase_t phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_DIRECT: if (start_i)    phase_d = PH_HIGH;
         PH_HIGH:   if (!send_en_i) phase_d = PH_MID;
         PH_MID:    if (!send_en_i) phase_d = PH_LOW;
         PH_LOW:    if (!send_en_i) phase_d = PH_DIRECT;
         default:                   phase_d = PH_DIRECT;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) phase_q <= PH_DIRECT;
      else         phase_q <= phase_d;
   end

   assign active_o = (phase_q != PH_DIRECT);
   assign sel_o    = {phase_q == PH_HIGH, phase_q == PH_MID, phase_q == PH_LOW};
endmodule

// File: rtl/hsq_bus_drive.sv
module hsq_bus_drive #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 3
) (
   input  logic                          active_i,
   input  logic [NBYTES-1:0]             hs_sel_i,
   input  logic [NBYTES-1:0]             pin_en_i,
   input  logic                          pin_ce_i,
   input  logic [NBYTES-1:0][BYTE_W-1:0] bytes_i,
   output logic [NBYTES-1:0]             en_val_o,
   output logic                          en_oe_o,
   output logic                          ce_val_o,
   output logic [BYTE_W-1:0]             data_o,
   output logic                          data_oe_o
);
   logic [NBYTES-1:0] host_sel;
   logic [NBYTES-1:0] rd_sel;

   // direct mode: highest raised enable wins, gated by chip enable
   always_comb begin
      host_sel = '0;
      for (int i = NBYTES - 1; i >= 0; i--) begin
         if (pin_ce_i && pin_en_i[i] && (host_sel == '0)) host_sel[i] = 1'b1;
      end
   end

   assign rd_sel = active_i ? hs_sel_i : host_sel;

   always_comb begin
      data_o = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (rd_sel[i]) data_o = bytes_i[i];
      end
   end

   assign data_oe_o = |rd_sel;
   assign en_val_o  = hs_sel_i;
   assign en_oe_o   = active_i;
   assign ce_val_o  = 1'b1;
endmodule

// File: rtl/byte_handshake_seq.sv
module byte_handshake_seq
   import hsq_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_i,
   input  logic              send_en_i,
   input  logic              conv_done_i,
   input  logic [DATA_W-1:0] result_i,
   input  logic              polarity_i,
   input  logic              overrange_i,
   input  logic              zero_cross_i,
   inout  wire  [BYTE_W-1:0] data_io,
   inout  wire               hi_en_io,
   inout  wire               mid_en_io,
   inout  wire               lo_en_io,
   inout  wire               ce_load_io,
   output logic              latch_pulse_o,
   output logic              status_o
);
   localparam int unsigned NB = HSQ_NBYTES;

   logic                      start;
   logic                      hs_active;
   logic [NB-1:0]             hs_sel;
   logic [NB-1:0][BYTE_W-1:0] bytes;
   logic [NB-1:0]             en_val;
   logic                      en_oe;
   logic                      ce_val;
   logic [BYTE_W-1:0]         data_val;
   logic                      data_oe;
   logic [NB-1:0]             pin_en;

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("byte_handshake_seq: BYTE_W must hold both flags");
      end
   endgenerate

   assign pin_en = {hi_en_io, mid_en_io, lo_en_io};

   hsq_mode_detect #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode_i),
      .send_en_i (send_en_i),
      .busy_i    (hs_active),
      .start_o   (start)
   );

   hsq_sequencer u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .send_en_i (send_en_i),
      .active_o  (hs_active),
      .sel_o     (hs_sel)
   );

   hsq_result_latch #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NBYTES(NB)) u_latch (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .conv_done_i   (conv_done_i),
      .inhibit_i     (hs_active),
      .result_i      (result_i),
      .polarity_i    (polarity_i),
      .overrange_i   (overrange_i),
      .latch_pulse_o (latch_pulse_o),
      .bytes_o       (bytes)
   );

   hsq_bus_drive #(.BYTE_W(BYTE_W), .NBYTES(NB)) u_bus (
      .active_i  (hs_active),
      .hs_sel_i  (hs_sel),
      .pin_en_i  (pin_en),
      .pin_ce_i  (ce_load_io),
      .bytes_i   (bytes),
      .en_val_o  (en_val),
      .en_oe_o   (en_oe),
      .ce_val_o  (ce_val),
      .data_o    (data_val),
      .data_oe_o (data_oe)
   );

   assign data_io    = data_oe ? data_val  : {BYTE_W{1'bz}};
   assign hi_en_io   = en_oe   ? en_val[2] : 1'bz;
   assign mid_en_io  = en_oe   ? en_val[1] : 1'bz;
   assign lo_en_io   = en_oe   ? en_val[0] : 1'bz;
   assign ce_load_io = en_oe   ? ce_val    : 1'bz;

   // status follows the conversion cycle only; mode plays no part
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           status_o <= 1'b0;
      else if (zero_cross_i) status_o <= 1'b1;
      else if (conv_done_i)  status_o <= 1'b0;
   end
endmodule

// File: rtl/hsq_checker.sv
module hsq_checker #(
   parameter int unsigned NBYTES = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              hs_active,
   input logic [NBYTES-1:0] hs_sel,
   input logic              send_en,
   input logic              en_oe,
   input logic              latch_pulse,
   input logic              zero_cross,
   input logic              status
);
   AST_ONE_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hs_sel)) else $error("enables overlap"); // R3

   AST_DIRECT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hs_active |-> !en_oe) else $error("enables driven in direct mode"); // R2

   AST_NO_LATCH_IN_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hs_active |-> !latch_pulse) else $error("latch pulse during transfer"); // R6

   AST_HOLD_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hs_active && send_en) |=> (hs_active && $stable(hs_sel))) else $error("byte not held"); // R4

   AST_HIGH_TO_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hs_sel[2] && !send_en) |=> hs_sel[1]) else $error("order broken"); // R4

   AST_EXIT_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hs_sel[0] && !send_en) |=> !hs_active) else $error("no exit after low byte"); // R7

   AST_ENTRY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_active) |-> hs_sel[2]) else $error("entry not at high byte"); // R1

   AST_TIED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hs_active && send_en) |=> !hs_active) else $error("entry while held high"); // R8

   AST_STATUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_cross |=> status) else $error("status not set"); // R9
endmodule

bind byte_handshake_seq hsq_checker #(.NBYTES(3)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .hs_active   (hs_active),
   .hs_sel      (hs_sel),
   .send_en     (send_en_i),
   .en_oe       (en_oe),
   .latch_pulse (latch_pulse_o),
   .zero_cross  (zero_cross_i),
   .status      (status_o)
);

// File: tb/byte_handshake_seq_tb_top.sv
`timescale 1ns/1ps
module byte_handshake_seq_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode = 1'b0, send_en = 1'b1, conv_done = 1'b0, zc = 1'b0;
   logic [15:0] res = '0;
   logic pol = 1'b0, ovr = 1'b0;
   logic h_oe = 1'b1, h_hi = 1'b0, h_mid = 1'b0, h_lo = 1'b0, h_ce = 1'b0;
   logic d_oe = 1'b0;
   wire [7:0] data_w;
   wire hi_w, mid_w, lo_w, ce_w;
   wire latch_w, status_w;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic st_exp = 1'b0;
   logic [15:0] e_res = '0;
   logic e_pol = 1'b0, e_ovr = 1'b0;

   always #2 clk = ~clk;

   assign data_w = d_oe ? 8'h00 : 8'hzz;
   assign hi_w   = h_oe ? h_hi  : 1'bz;
   assign mid_w  = h_oe ? h_mid : 1'bz;
   assign lo_w   = h_oe ? h_lo  : 1'bz;
   assign ce_w   = h_oe ? h_ce  : 1'bz;

   byte_handshake_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .send_en_i(send_en),
      .conv_done_i(conv_done), .result_i(res), .polarity_i(pol),
      .overrange_i(ovr), .zero_cross_i(zc), .data_io(data_w),
      .hi_en_io(hi_w), .mid_en_io(mid_w), .lo_en_io(lo_w), .ce_load_io(ce_w),
      .latch_pulse_o(latch_w), .status_o(status_w)
   );

   // status model from R9
   always @(posedge clk) begin
      if (!rst_n)        st_exp <= 1'b0;
      else if (zc)       st_exp <= 1'b1;
      else if (conv_done) st_exp <= 1'b0;
   end

   function automatic logic [7:0] exp_byte(logic [15:0] r, logic p, logic o, int idx);
      logic [23:0] w;
      w = {p, o, r, 6'b000000};
      return w[23 - 8*idx -: 8];
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic host_idle();
      h_oe = 1'b1; h_hi = 1'b0; h_mid = 1'b0; h_lo = 1'b0; h_ce = 1'b0;
   endtask

   task automatic load(logic [15:0] r, logic p, logic o);
      @(negedge clk);
      res = r; pol = p; ovr = o; conv_done = 1'b1;
      #0.5 chk("R6", "latch pulse in direct", {31'd0, latch_w}, 32'd1);
      @(posedge clk);
      e_res = r; e_pol = p; e_ovr = o;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic direct_read(logic ce, logic [2:0] en, int exp_idx, string req);
      @(negedge clk);
      h_oe = 1'b1; h_ce = ce; {h_hi, h_mid, h_lo} = en;
      d_oe = (exp_idx < 0);
      #0.5;
      if (exp_idx < 0) chk(req, "bus released", {24'd0, data_w}, 32'd0);
      else chk(req, "direct byte", {24'd0, data_w}, {24'd0, exp_byte(e_res, e_pol, e_ovr, exp_idx)});
      @(negedge clk);
      host_idle(); d_oe = 1'b0;
   endtask

   task automatic transfer(int inhibit_at);
      int idx;
      int cyc;
      @(negedge clk);
      host_idle(); h_oe = 1'b0; mode = 1'b1; send_en = 1'b0;
      @(posedge clk);
      idx = 0; cyc = 0;
      while (idx < 3) begin
         @(negedge clk);
         conv_done = 1'b0;
         chk("R3", "enables", {29'd0, hi_w, mid_w, lo_w}, {29'd0, 3'b100 >> idx});
         chk("R3", "ce/load driven", {31'd0, ce_w}, 32'd1);
         chk("R5", "handshake byte", {24'd0, data_w}, {24'd0, exp_byte(e_res, e_pol, e_ovr, idx)});
         chk("R9", "status in handshake", {31'd0, status_w}, {31'd0, st_exp});
         send_en = ($urandom % 3 == 0);
         if (cyc == inhibit_at && idx < 2) begin
            conv_done = 1'b1; res = 16'($urandom); pol = ~e_pol; ovr = ~e_ovr;
            #0.5 chk("R6", "latch inhibited", {31'd0, latch_w}, 32'd0);
         end
         @(posedge clk);
         if (!send_en) idx++;
         cyc++;
      end
      @(negedge clk);
      conv_done = 1'b0; host_idle();
      #0.5 chk("R7", "lines released", {28'd0, hi_w, mid_w, lo_w, ce_w}, 32'd0);
      repeat (3) begin
         @(negedge clk);
         send_en = 1'b0;
         #0.5 chk("R1", "level no re-entry", {28'd0, hi_w, mid_w, lo_w, ce_w}, 32'd0);
      end
      @(negedge clk);
      mode = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      #0.5 chk("R10", "reset enables", {28'd0, hi_w, mid_w, lo_w, ce_w}, 32'd0);
      chk("R10", "reset status", {31'd0, status_w}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      direct_read(1'b1, 3'b100, 0, "R10");
      direct_read(1'b1, 3'b001, 2, "R10");

      // directed corner values
      load(16'hFFFF, 1'b1, 1'b1);
      direct_read(1'b1, 3'b101, 0, "R2");
      direct_read(1'b1, 3'b011, 1, "R2");
      direct_read(1'b1, 3'b001, 2, "R5");
      direct_read(1'b0, 3'b100, -1, "R2");
      direct_read(1'b1, 3'b000, -1, "R2");
      transfer(1);
      direct_read(1'b1, 3'b100, 0, "R6");

      // status set and clear
      @(negedge clk); zc = 1'b1;
      @(negedge clk); zc = 1'b0;
      chk("R9", "status set", {31'd0, status_w}, 32'd1);
      load(16'h8001, 1'b0, 1'b1);
      chk("R9", "status cleared", {31'd0, status_w}, 32'd0);

      // send-enable tied high: rising mode edge ignored
      @(negedge clk); send_en = 1'b1; mode = 1'b1;
      repeat (2) @(negedge clk);
      send_en = 1'b0;
      #0.5 chk("R8", "no entry while held", {28'd0, hi_w, mid_w, lo_w, ce_w}, 32'd0);
      @(negedge clk);
      #0.5 chk("R8", "level after tie-high", {28'd0, hi_w, mid_w, lo_w, ce_w}, 32'd0);
      @(negedge clk); mode = 1'b0; send_en = 1'b1;
      @(negedge clk);

      // constrained random rounds
      for (int n = 0; n < 12; n++) begin
         load(16'($urandom), 1'($urandom), 1'($urandom));
         if (n % 3 == 0) begin
            @(negedge clk); zc = 1'b1;
            @(negedge clk); zc = 1'b0;
         end
         transfer(int'($urandom % 4));
         direct_read(1'b1, 3'b010, 1, "R6");
      end

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule